// File: doc/BRIEF.md
# Batch Merge Sorter

The block collects a batch of signed values from a streaming input and keeps them in an on-chip primary memory. It then sorts them in place with a bottom-up merge sort and streams them out in ascending order. Sorting starts from runs of a single element. Each pass merges every pair of neighbouring runs into a scratch memory, so the run length doubles on every pass. After each pass the merged data is copied back into the primary memory. When one run spans the whole batch, the output phase begins.

Both memories are single-port and have one cycle of read latency. The input, sort and output phases run one after the other. One incrementer serves all the counters that step through the memories. Input is accepted only while the block is in its input phase. A one-cycle completion pulse marks the end of each batch, and the block is then ready for the next one.

Top module: `merge_sorter`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `done` is 0.
- R2: The block accepts exactly 2^LOG_N values, one for each cycle in which `in_valid` and `in_ready` are both 1. It then drops `in_ready` to 0 on the next cycle.
- R3: The values leave in non-decreasing order, where each W-bit word is read as a two's-complement number (for W=9, 9'h100 is -256 and 9'h0FF is 255).
- R4: The output batch is a permutation of the input batch, with every duplicate kept exactly as often as it arrived.
- R5: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` does not change.
- R6: `done` is 1 for exactly the single cycle after the last output value is accepted. In that same cycle `in_ready` is 1 again.
- R7: `in_ready` and `out_valid` are never both 1. While the sort runs, `in_valid` and `in_data` have no effect on the batch being sorted.
- R8: A batch sorted after an earlier one depends only on its own input values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Block accepts input words |
| in_data | input | W | Signed input word |
| out_valid | output | 1 | Sorted word offered |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | W | Sorted signed word |
| done | output | 1 | One-cycle pulse after the last output word |

## Verification
The hardest cases to reach are the ends of a merge where one run is used up while the other still holds elements, and ties between the two runs. These only happen deep inside passes that cannot be seen from the ports. The stimulus reaches them with three kinds of batch. The first is a reversed batch that includes both extreme values, so that every pair merge drains its right run first. The second is a batch drawn from only four distinct values, so that equal heads meet constantly. The third is a random batch. Two of these batches run under random output backpressure, with input offered while the sort runs, and the block is reused across batches.

// File: rtl/merge_sorter.sv
module merge_sorter #(
  parameter int W     = 9,
  parameter int LOG_N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         done
);
  localparam int N  = 1 << LOG_N;
  localparam int AW = LOG_N;
  localparam int CW = LOG_N + 1;

  typedef enum logic [2:0] {S_IN, S_RL, S_RR, S_WR, S_CR, S_CW, S_OR, S_OV} st_t;
  st_t st;

  logic [AW-1:0] ptr;
  logic [CW-1:0] base, run, lc, rc;
  logic [W-1:0]  hl, ra_q, rb_q;
  logic [W-1:0]  mem_a [N];
  logic [W-1:0]  mem_b [N];

  logic [CW-1:0] li, ri, k, pair_len, inc_src, inc;
  logic          l_end, r_end, take_l, ptr_last, pair_last;
  logic [AW-1:0] addr_a, addr_b;
  logic          we_a, we_b;
  logic [W-1:0]  wd_a, wd_b;

  assign l_end     = lc == run;
  assign r_end     = rc == run;
  assign take_l    = r_end || (!l_end && $signed(hl) <= $signed(ra_q));
  assign li        = base + lc;
  assign ri        = base + run + rc;
  assign k         = base + lc + rc;
  assign pair_len  = run << 1;
  assign pair_last = (lc + rc + CW'(1)) == pair_len;
  assign ptr_last  = ptr == AW'(N - 1);

  assign inc_src = (st == S_WR) ? (take_l ? lc : rc) : {1'b0, ptr};
  assign inc     = inc_src + CW'(1);

  always_comb begin
    case (st)
      S_RL:    addr_a = li[AW-1:0];
      S_RR:    addr_a = ri[AW-1:0];
      default: addr_a = ptr;
    endcase
  end
  assign we_a   = (st == S_IN && in_valid) || st == S_CW;
  assign wd_a   = (st == S_IN) ? in_data : rb_q;
  assign addr_b = (st == S_WR) ? k[AW-1:0] : ptr;
  assign we_b   = st == S_WR;
  assign wd_b   = take_l ? hl : ra_q;

  always_ff @(posedge clk) begin
    if (we_a) mem_a[addr_a] <= wd_a;
    ra_q <= mem_a[addr_a];
  end

  always_ff @(posedge clk) begin
    if (we_b) mem_b[addr_b] <= wd_b;
    rb_q <= mem_b[addr_b];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IN;
      ptr  <= '0;
      base <= '0;
      run  <= CW'(1);
      lc   <= '0;
      rc   <= '0;
      hl   <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IN: if (in_valid) begin
          ptr <= inc[AW-1:0];
          if (ptr_last) begin
            st   <= S_RL;
            base <= '0;
            run  <= CW'(1);
            lc   <= '0;
            rc   <= '0;
          end
        end
        S_RL: st <= S_RR;
        S_RR: begin
          hl <= ra_q;
          st <= S_WR;
        end
        S_WR: begin
          if (take_l) lc <= inc;
          else        rc <= inc;
          st <= S_RL;
          if (pair_last) begin
            lc <= '0;
            rc <= '0;
            if (base + pair_len == CW'(N)) st <= S_CR;
            else base <= base + pair_len;
          end
        end
        S_CR: st <= S_CW;
        S_CW: begin
          ptr <= inc[AW-1:0];
          st  <= S_CR;
          if (ptr_last) begin
            run  <= pair_len;
            base <= '0;
            st   <= (pair_len == CW'(N)) ? S_OR : S_RL;
          end
        end
        S_OR: st <= S_OV;
        S_OV: if (out_ready) begin
          ptr <= inc[AW-1:0];
          if (ptr_last) begin
            st   <= S_IN;
            done <= 1'b1;
          end else st <= S_OR;
        end
        default: st <= S_IN;
      endcase
    end
  end

  assign in_ready  = st == S_IN;
  assign out_valid = st == S_OV;
  assign out_data  = ra_q;
endmodule

// File: rtl/merge_sorter_chk.sv
module merge_sorter_chk #(
  parameter int W     = 9,
  parameter int LOG_N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data,
  input logic         done
);
  localparam int N = 1 << LOG_N;

  logic [LOG_N:0] cnt_in;
  logic           have_prev;
  logic [W-1:0]   prev;

  always_ff @(posedge clk) begin
    if (!rst_n || done) begin
      cnt_in    <= '0;
      have_prev <= 1'b0;
      prev      <= '0;
    end else begin
      if (in_valid && in_ready) cnt_in <= cnt_in + 1'b1;
      if (out_valid && out_ready) begin
        have_prev <= 1'b1;
        prev      <= out_data;
      end
    end
  end

  p_in_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && cnt_in == (LOG_N+1)'(N - 1)) |=> !in_ready);

  p_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && have_prev) |-> $signed(out_data) >= $signed(prev));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_done_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(out_valid && out_ready) && in_ready));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));
endmodule

bind merge_sorter merge_sorter_chk #(.W(W), .LOG_N(LOG_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .done(done)
);

// File: tb/merge_sorter_tb.sv
module merge_sorter_tb;
  localparam int W = 9;
  localparam int LOG_N = 8;
  localparam int N = 1 << LOG_N;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 0;
  logic [W-1:0] in_data = '0;
  logic in_ready, out_valid, done;
  logic [W-1:0] out_data;

  int checks = 0, errors = 0;
  int vals[N];
  logic [W-1:0] expq[$];
  int popped = 0;
  int bp_mode = 0;
  bit expect_done = 0;
  bit finished = 0;

  merge_sorter #(.W(W), .LOG_N(LOG_N)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Driver: feed a batch and push the sorted expectation into the scoreboard
  task automatic run_batch(input bit poke_during_sort);
    int s[N];
    for (int i = 0; i < N; i++) s[i] = vals[i];
    for (int i = 1; i < N; i++) begin
      int key = s[i];
      int j = i - 1;
      while (j >= 0 && s[j] > key) begin
        s[j+1] = s[j];
        j--;
      end
      s[j+1] = key;
    end
    for (int i = 0; i < N; i++) expq.push_back(W'(s[i]));
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      in_valid = 1;
      in_data  = W'(vals[i]);
      #1;
      while (!in_ready) begin
        @(negedge clk);
        #1;
      end
      @(negedge clk);
    end
    in_valid = 0;
    #1;
    check(in_ready == 0, "R2 in_ready after full batch", in_ready, 0);
    check(out_valid == 0, "R7 out_valid during sort", out_valid, 0);
    if (poke_during_sort) begin
      for (int i = 0; i < 200; i++) begin
        in_valid = 1;
        in_data  = W'(i);
        @(negedge clk);
      end
      in_valid = 0;
    end
    while (expq.size() != 0 || expect_done) @(negedge clk);
  endtask

  // Monitor: compare each accepted output against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      out_ready = (bp_mode == 0) ? 1'b1 : ($urandom % 3 != 0);
      #1;
      if (expect_done) begin
        check(done == 1, "R6 done pulse", done, 1);
        check(in_ready == 1, "R6 in_ready back", in_ready, 1);
        expect_done = 0;
      end else if (rst_n) begin
        if (done) check(0, "R6 spurious done", done, 0);
        if (in_ready && out_valid) check(0, "R7 overlap", 1, 0);
      end
      if (out_valid && out_ready) begin
        if (expq.size() == 0) check(0, "R4 extra output", int'($signed(out_data)), 0);
        else begin
          logic [W-1:0] e;
          e = expq.pop_front();
          check(out_data == e, "R3 R4 sorted value", int'($signed(out_data)), int'($signed(e)));
          popped++;
          if (expq.size() == 0) expect_done = 1;
        end
      end
      if (out_valid && !out_ready) begin
        logic [W-1:0] held;
        held = out_data;
        @(posedge clk);
        #1;
        check(out_valid && out_data == held, "R5 hold under backpressure",
              int'(out_data), int'(held));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(in_ready == 1, "R1 reset in_ready", in_ready, 1);
    check(out_valid == 0, "R1 reset out_valid", out_valid, 0);
    check(done == 0, "R1 reset done", done, 0);
    @(negedge clk);
    rst_n = 1;

    // random batch, no backpressure
    bp_mode = 0;
    for (int i = 0; i < N; i++) vals[i] = int'($urandom % 512) - 256;
    run_batch(0);

    // reversed batch with both extremes, backpressure, input poked during sort
    bp_mode = 1;
    for (int i = 0; i < N; i++) vals[i] = 255 - 2 * i;
    vals[N-1] = -256;
    run_batch(1);

    // heavy duplicates, reuse after earlier batches (R8)
    for (int i = 0; i < N; i++) vals[i] = int'($urandom % 4) - 2;
    run_batch(1);

    check(popped == 3 * N, "R4 R8 total outputs", popped, 3 * N);
    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule